// File: doc/BRIEF.md
# Configurable Macrocell Storage Element

A single storage bit at the output of a programmable-logic cell. A set of configuration inputs decides whether the bit behaves as an edge-triggered D register, an edge-triggered toggle register or a level-sensitive transparent latch. They also decide which clock drives it, the clock polarity, the polarity of the data, and the value loaded at power-up. In front of the storage bit, an XOR stage combines the ORed sum-of-products terms with one extra product term. Two emulation settings reuse that stage to build J-K and S-R behaviour from the term array.

The block runs on one system clock `clk_i`. The four shared block clocks and the individual product-term clock are treated as sampled signals. An active edge is seen at the first system-clock edge at which the selected clock shows its new level. The initialization inputs are independent of the selected storage clock and act on the next system-clock edge. Power-on has the highest priority, then reset, then preset, then normal storage. The block-wide reset and preset terms act only in synchronous clock mode.

Top module: `mcell_store`

## Requirements
- R1: While `por_i` is high, Q takes the value of `pu_i` at the next system clock, whatever the other inputs are.
- R2: With `amode_i`=0 and `por_i` low, `blk_rst_i` high forces Q to 0 at the next system clock even if `blk_set_i` is also high. `blk_set_i` high alone forces Q to 1. No storage-clock edge is needed for either.
- R3: With `amode_i`=1, `blk_rst_i` and `blk_set_i` have no effect on Q.
- R4: With `kind_i`=0 (D register; code 3 behaves the same) and `emul_i`=0, Q loads the data bit on an active edge and holds otherwise. The active edge is rising when `cinv_i`=0 and falling when `cinv_i`=1.
- R5: With `kind_i`=1 (toggle register) and `emul_i`=0, Q inverts on an active edge when the data bit is 1 and holds when it is 0.
- R6: With `kind_i`=2 (latch) and `emul_i`=0, Q takes the data bit at every system clock while the selected clock is at its active level (high when `cinv_i`=0, low when `cinv_i`=1) and holds at the other level.
- R7: With `emul_i` equal to 0 or 3, the data bit is (OR of all `sop_i`) XOR `xpt_i` XOR `inv_i`.
- R8: With `amode_i`=0 the selected clock is `blk_clk_i[csel_i]`; with `amode_i`=1 it is `pt_clk_i`. Clocks that are not selected have no effect.
- R9: With `emul_i`=1 (J-K), J is the OR of the lower half of `sop_i` and K the OR of the upper half, each inverted when `inv_i`=1. On an active edge Q becomes (J & ~Q) | (~K & Q) inverted as K dictates, i.e. toggles by T=(J&~Q)|(K&Q). `xpt_i` and `kind_i` are ignored.
- R10: With `emul_i`=2 (S-R), S is taken from the lower half and R from the upper half with the same polarity rule. On an active edge Q becomes ~R & (S | Q), so S and R together give 0.
- R11: While `rst_ni` is low, Q equals `pu_i`. A selected clock that is already at its active level when reset is released does not count as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| kind_i | input | 2 | Storage type: 0 D, 1 toggle, 2 latch, 3 D |
| emul_i | input | 2 | Emulation: 0 none, 1 J-K, 2 S-R, 3 none |
| inv_i | input | 1 | Data polarity invert |
| amode_i | input | 1 | 0 synchronous (block clocks), 1 asynchronous (product-term clock) |
| csel_i | input | 2 | Block clock select |
| cinv_i | input | 1 | Clock/enable polarity: 0 rising/high, 1 falling/low |
| pu_i | input | 1 | Power-up value of Q |
| sop_i | input | 4 | Sum-of-products terms |
| xpt_i | input | 1 | Extra product term into the XOR stage |
| blk_clk_i | input | 4 | Shared block clocks |
| pt_clk_i | input | 1 | Individual product-term clock |
| blk_rst_i | input | 1 | Block-wide reset term |
| blk_set_i | input | 1 | Block-wide preset term |
| por_i | input | 1 | Power-on strobe |
| q_o | output | 1 | Stored output |

## Verification
Every combination of storage type, emulation, polarity, clock mode, clock select, clock polarity and power-up value is driven with random term, clock and initialization patterns. A bench model predicts each Q. The random clocks produce both held levels and edges. This separates edge behaviour from level behaviour and rising edges from falling edges. The random terms separate J from K and S from R, and they catch the case where both are asserted together. Directed sequences hold the selected clock still while the unselected clocks toggle. They also assert the block reset and preset in asynchronous mode, and release reset with the clock already at its active level. These show that inputs which should be ignored leave Q unchanged.

// File: rtl/mcell_pkg.sv
package mcell_pkg;
  typedef enum logic [1:0] {
    KIND_D   = 2'd0,
    KIND_T   = 2'd1,
    KIND_LAT = 2'd2,
    KIND_D2  = 2'd3
  } kind_t;

  typedef enum logic [1:0] {
    EMUL_NONE  = 2'd0,
    EMUL_JK    = 2'd1,
    EMUL_SR    = 2'd2,
    EMUL_NONE2 = 2'd3
  } emul_t;
endpackage

// File: rtl/mcell_clk_pick.sv
module mcell_clk_pick #(
  parameter int NBCLK = 4,
  localparam int CSW = (NBCLK > 1) ? $clog2(NBCLK) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NBCLK-1:0] blk_clk_i,
  input  logic             pt_clk_i,
  input  logic             amode_i,
  input  logic [CSW-1:0]   csel_i,
  input  logic             cinv_i,
  output logic             lvl_o,
  output logic             edge_o
);
  logic [NBCLK-1:0] hit;
  logic             lvl_q;

  for (genvar g = 0; g < NBCLK; g++) begin : g_hit
    assign hit[g] = blk_clk_i[g] & (csel_i == CSW'(g));
  end

  assign lvl_o  = (amode_i ? pt_clk_i : |hit) ^ cinv_i;
  assign edge_o = lvl_o & ~lvl_q;

  // history starts at active level: no false edge out of reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b1;
    else         lvl_q <= lvl_o;
  end
endmodule

// File: rtl/mcell_din.sv
module mcell_din
  import mcell_pkg::*;
#(
  parameter int NTERM = 4,
  localparam int HALF = NTERM / 2
) (
  input  logic [NTERM-1:0] sop_i,
  input  logic             xpt_i,
  input  logic             inv_i,
  input  kind_t            kind_i,
  input  emul_t            emul_i,
  input  logic             q_i,
  output kind_t            mode_o,
  output logic             bit_o
);
  logic lo, hi;

  assign lo = (|sop_i[HALF-1:0])     ^ inv_i;
  assign hi = (|sop_i[NTERM-1:HALF]) ^ inv_i;

  always_comb begin
    unique case (emul_i)
      EMUL_JK: begin
        mode_o = KIND_T;
        bit_o  = (lo & ~q_i) | (hi & q_i);
      end
      EMUL_SR: begin
        mode_o = KIND_D;
        bit_o  = ~hi & (lo | q_i);
      end
      default: begin
        mode_o = (kind_i == KIND_D2) ? KIND_D : kind_i;
        bit_o  = (|sop_i) ^ xpt_i ^ inv_i;
      end
    endcase
  end
endmodule

// File: rtl/mcell_core.sv
module mcell_core
  import mcell_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  pu_i,
  input  logic  por_i,
  input  logic  init_en_i,
  input  logic  rst_pt_i,
  input  logic  set_pt_i,
  input  kind_t mode_i,
  input  logic  bit_i,
  input  logic  lvl_i,
  input  logic  edge_i,
  output logic  q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      q_q <= pu_i;
    else if (por_i)                   q_q <= pu_i;
    else if (init_en_i && rst_pt_i)   q_q <= 1'b0;
    else if (init_en_i && set_pt_i)   q_q <= 1'b1;
    else begin
      unique case (mode_i)
        KIND_T:   if (edge_i) q_q <= q_q ^ bit_i;
        KIND_LAT: if (lvl_i)  q_q <= bit_i;
        default:  if (edge_i) q_q <= bit_i;
      endcase
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/mcell_store.sv
module mcell_store
  import mcell_pkg::*;
#(
  parameter int NTERM = 4,
  parameter int NBCLK = 4,
  localparam int CSW = (NBCLK > 1) ? $clog2(NBCLK) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       kind_i,
  input  logic [1:0]       emul_i,
  input  logic             inv_i,
  input  logic             amode_i,
  input  logic [CSW-1:0]   csel_i,
  input  logic             cinv_i,
  input  logic             pu_i,
  input  logic [NTERM-1:0] sop_i,
  input  logic             xpt_i,
  input  logic [NBCLK-1:0] blk_clk_i,
  input  logic             pt_clk_i,
  input  logic             blk_rst_i,
  input  logic             blk_set_i,
  input  logic             por_i,
  output logic             q_o
);
  logic  lvl, edg, dbit;
  kind_t mode;

  mcell_clk_pick #(.NBCLK(NBCLK)) u_clk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .blk_clk_i(blk_clk_i),
    .pt_clk_i (pt_clk_i),
    .amode_i  (amode_i),
    .csel_i   (csel_i),
    .cinv_i   (cinv_i),
    .lvl_o    (lvl),
    .edge_o   (edg)
  );

  mcell_din #(.NTERM(NTERM)) u_din (
    .sop_i (sop_i),
    .xpt_i (xpt_i),
    .inv_i (inv_i),
    .kind_i(kind_t'(kind_i)),
    .emul_i(emul_t'(emul_i)),
    .q_i   (q_o),
    .mode_o(mode),
    .bit_o (dbit)
  );

  mcell_core u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pu_i     (pu_i),
    .por_i    (por_i),
    .init_en_i(~amode_i),
    .rst_pt_i (blk_rst_i),
    .set_pt_i (blk_set_i),
    .mode_i   (mode),
    .bit_i    (dbit),
    .lvl_i    (lvl),
    .edge_i   (edg),
    .q_o      (q_o)
  );
endmodule

// File: rtl/mcell_store_chk.sv
module mcell_store_chk #(
  parameter int NTERM = 4,
  parameter int NBCLK = 4,
  localparam int CSW = (NBCLK > 1) ? $clog2(NBCLK) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [1:0]       kind_i,
  input logic [1:0]       emul_i,
  input logic             inv_i,
  input logic             amode_i,
  input logic [CSW-1:0]   csel_i,
  input logic             cinv_i,
  input logic             pu_i,
  input logic [NTERM-1:0] sop_i,
  input logic             xpt_i,
  input logic [NBCLK-1:0] blk_clk_i,
  input logic             pt_clk_i,
  input logic             blk_rst_i,
  input logic             blk_set_i,
  input logic             por_i,
  input logic             q_o
);
  logic lvl_now, dplain, quiet, plain;

  assign lvl_now = (amode_i ? pt_clk_i : blk_clk_i[csel_i]) ^ cinv_i;
  assign dplain  = ((|sop_i) ^ xpt_i) ^ inv_i;
  assign quiet   = !por_i && (amode_i || !(blk_rst_i || blk_set_i));
  assign plain   = (emul_i == 2'd0) || (emul_i == 2'd3);

  assert_por_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (q_o == $past(pu_i)));

  assert_rst_wins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!por_i && !amode_i && blk_rst_i) |=> !q_o);

  assert_set_alone_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!por_i && !amode_i && !blk_rst_i && blk_set_i) |=> q_o);

  assert_latch_follow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && plain && kind_i == 2'd2 && lvl_now) |=> (q_o == $past(dplain)));

  assert_d_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && plain && (kind_i == 2'd0 || kind_i == 2'd3) && (lvl_now == $past(lvl_now)))
      |=> $stable(q_o));

  assert_sr_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet && emul_i == 2'd2 && ((|sop_i[NTERM-1:NTERM/2]) ^ inv_i) && lvl_now
      && !$past(lvl_now)) |=> !q_o);
endmodule

bind mcell_store mcell_store_chk #(.NTERM(NTERM), .NBCLK(NBCLK)) u_chk (.*);

// File: tb/mcell_store_bench.sv
module mcell_store_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] kind_i = '0, emul_i = '0, csel_i = '0;
  logic       inv_i = 0, amode_i = 0, cinv_i = 0, pu_i = 1;
  logic [3:0] sop_i = '0, blk_clk_i = '0;
  logic       xpt_i = 0, pt_clk_i = 0, blk_rst_i = 0, blk_set_i = 0, por_i = 0;
  logic       q_o;

  int total = 0, bad = 0;
  logic exp_q, prev_lvl;

  always #4 clk = ~clk;

  mcell_store u_mcell_store (
    .clk_i(clk), .rst_ni(rst_ni), .kind_i(kind_i), .emul_i(emul_i), .inv_i(inv_i),
    .amode_i(amode_i), .csel_i(csel_i), .cinv_i(cinv_i), .pu_i(pu_i), .sop_i(sop_i),
    .xpt_i(xpt_i), .blk_clk_i(blk_clk_i), .pt_clk_i(pt_clk_i), .blk_rst_i(blk_rst_i),
    .blk_set_i(blk_set_i), .por_i(por_i), .q_o(q_o)
  );

  task automatic check(input string tag, input logic act, input logic expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s q=%0b expected=%0b at %0t", tag, act, expv, $time);
    end
  endtask

  // model one system-clock step from current inputs, then compare
  task automatic step(input string force_tag);
    string t;
    logic lvl, edg, j, k, d;
    lvl = (amode_i ? pt_clk_i : blk_clk_i[csel_i]) ^ cinv_i;
    edg = lvl && !prev_lvl;
    prev_lvl = lvl;
    j = (sop_i[0] | sop_i[1]) ^ inv_i;
    k = (sop_i[2] | sop_i[3]) ^ inv_i;
    d = (sop_i != 0) ^ xpt_i ^ inv_i;
    if (por_i) begin exp_q = pu_i; t = "R1"; end
    else if (!amode_i && blk_rst_i) begin exp_q = 0; t = "R2"; end
    else if (!amode_i && blk_set_i) begin exp_q = 1; t = "R2"; end
    else if (emul_i == 2'd1) begin
      if (edg && ((j && !exp_q) || (k && exp_q))) exp_q = !exp_q;
      t = "R9";
    end else if (emul_i == 2'd2) begin
      if (edg) exp_q = !k && (j || exp_q);
      t = "R10";
    end else if (kind_i == 2'd1) begin
      if (edg && d) exp_q = !exp_q;
      t = "R5 R7";
    end else if (kind_i == 2'd2) begin
      if (lvl) exp_q = d;
      t = "R6 R7";
    end else begin
      if (edg) exp_q = d;
      t = "R4 R7";
    end
    if (force_tag != "") t = force_tag;
    @(posedge clk);
    #2;
    check(t, q_o, exp_q);
  endtask

  task automatic quiet_inputs();
    sop_i = '0; xpt_i = 0; blk_rst_i = 0; blk_set_i = 0; por_i = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R11: reset value and no edge at release with clock already active
    kind_i = 2'd0; emul_i = 2'd0; amode_i = 0; csel_i = 2'd0; cinv_i = 0; pu_i = 1;
    blk_clk_i = 4'b0001;
    repeat (3) @(posedge clk);
    #2 check("R11", q_o, 1'b1);
    @(negedge clk); rst_ni = 1;
    exp_q = 1; prev_lvl = 1;
    step("R11");
    @(negedge clk); blk_clk_i = 4'b0000; step("R4");
    @(negedge clk); blk_clk_i = 4'b0001; step("R4");
    check("R4", q_o, 1'b0);

    // R8: only selected block clock matters
    @(negedge clk); csel_i = 2'd2; blk_clk_i = 4'b0000; sop_i = 4'b0001; step("R8");
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); blk_clk_i = {~blk_clk_i[3], 1'b0, ~blk_clk_i[1:0]}; pt_clk_i = ~pt_clk_i;
      step("R8");
    end
    @(negedge clk); blk_clk_i[2] = 1; step("R8");
    check("R8", q_o, 1'b1);

    // R3: block init terms ignored in asynchronous mode
    @(negedge clk); amode_i = 1; pt_clk_i = 1; sop_i = '0; step("R3");
    @(negedge clk); sop_i = 4'b0001; blk_rst_i = 1; step("R3");
    check("R3", q_o, 1'b1);
    @(negedge clk); blk_rst_i = 0; sop_i = '0; pt_clk_i = 0; step("R3");
    @(negedge clk); pt_clk_i = 1; step("R3");
    @(negedge clk); blk_set_i = 1; step("R3");
    check("R3", q_o, 1'b0);
    @(negedge clk); quiet_inputs(); step("");

    // full configuration sweep with random stimulus
    for (int kd = 0; kd < 4; kd++)
      for (int em = 0; em < 4; em++)
        for (int iv = 0; iv < 2; iv++)
          for (int am = 0; am < 2; am++)
            for (int cs = 0; cs < 4; cs++)
              for (int ci = 0; ci < 2; ci++)
                for (int pu = 0; pu < 2; pu++)
                  for (int n = 0; n < 12; n++) begin
                    int unsigned r;
                    r = $urandom;
                    @(negedge clk);
                    kind_i = 2'(kd); emul_i = 2'(em); inv_i = iv[0]; amode_i = am[0];
                    csel_i = 2'(cs); cinv_i = ci[0]; pu_i = pu[0];
                    sop_i = r[3:0]; xpt_i = r[4]; blk_clk_i = r[8:5]; pt_clk_i = r[9];
                    blk_rst_i = (r[12:10] == 3'd0); blk_set_i = (r[15:13] == 3'd0);
                    por_i = (r[19:16] == 4'd0);
                    step("");
                  end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule